// File: doc/BRIEF.md
# Compare-and-Exchange Datapath

This block performs the arithmetic half of a compare-and-exchange operation. Each operation supplies three operand values: an accumulator, a destination and a source, plus an operand width code. The block subtracts the destination from the accumulator and produces all six arithmetic status flags exactly as a full subtraction would. The result of that subtraction then selects which register the block updates.

When the difference is zero, the source value replaces the destination. When the difference is not zero, the destination value is copied into the accumulator and the destination stays as it was. Only one of the two registers receives a write enable per operation. The block returns the new accumulator value, the new destination value, the two write enables and the flag vector, so a register file can retire the operation directly.

Narrow operations act on the low 8 or 16 bits. The bits above the selected width are ignored by the comparison. The written register keeps its previous value in those upper bits. A parameter chooses between a registered result stage with one cycle of latency and a purely combinational result.

Top module: `cxchg_unit`

## Requirements
- R1: The difference is accumulator minus destination, taken over the selected width. The zero flag, flags[3], is 1 exactly when that difference is zero.
- R2: The carry flag, flags[0], is 1 when the unsigned destination value exceeds the unsigned accumulator value over the selected width, which is a borrow out of the top bit.
- R3: The overflow flag, flags[5], is 1 when the signed difference of the two width-limited values cannot be represented in the selected width.
- R4: The sign flag, flags[4], equals the top bit of the width-limited difference.
- R5: The auxiliary carry flag, flags[2], is 1 when the low 4 bits of the destination exceed the low 4 bits of the accumulator, which is a borrow out of bit 3.
- R6: The parity flag, flags[1], is 1 when the low 8 bits of the difference hold an even number of ones.
- R7: On a zero difference, dst_we is 1 and acc_we is 0. dst_out carries the source value in the selected width, and acc_out equals acc_in.
- R8: On a non-zero difference, acc_we is 1 and dst_we is 0. acc_out carries the destination value in the selected width, and dst_out equals dst_in.
- R9: Width code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Operand bits above the selected width do not affect the flags or the outcome. The written register keeps its old bits above the selected width.
- R10: With the registered stage, res_valid and the result fields appear on the clock edge after the edge that sampled op_valid. When no operation is presented, res_valid and both write enables are 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_width | input | 2 | Width code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| acc_in | input | DATA_W | Current accumulator value |
| dst_in | input | DATA_W | Current destination value |
| src_in | input | DATA_W | Source value to be stored on a match |
| res_valid | output | 1 | Result fields are valid |
| acc_we | output | 1 | Accumulator write enable |
| acc_out | output | DATA_W | New accumulator value |
| dst_we | output | 1 | Destination write enable |
| dst_out | output | DATA_W | New destination value |
| flags | output | 6 | {overflow, sign, zero, aux, parity, carry} from bit 5 down to bit 0 |

## Verification
The bench builds the block with its defaults: DATA_W of 32 and the registered result stage. Those defaults make every width code reachable, and the one-cycle latency of R10 can be observed at the ports. Directed operands target the signed overflow boundaries, nibble borrows, equal values that differ only above the selected width, and both parities. A long run of pseudo-random operands, with matches forced in a fraction of them, covers flag combinations across all three widths.

// File: rtl/cxchg_pkg.sv
package cxchg_pkg;

   // Width selector codes; 3 is an alias of the 32-bit width.
   typedef enum logic [1:0] {
      WID_8   = 2'd0,
      WID_16  = 2'd1,
      WID_32  = 2'd2,
      WID_32X = 2'd3
   } width_e;

   localparam int NUM_LANES = 3;
   localparam int MAX_OP_W  = 32;
   localparam int FLAG_W    = 6;

   // Packed flag word, MSB first: bit 5 overflow ... bit 0 carry.
   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } flags_t;

   // Lane index for a width code.
   function automatic int unsigned lane_of(width_e w);
      case (w)
         WID_8:   lane_of = 0;
         WID_16:  lane_of = 1;
         default: lane_of = 2;
      endcase
   endfunction

   // Number of operand bits for a lane.
   function automatic int unsigned lane_bits(int unsigned lane);
      lane_bits = 8 << lane;
   endfunction

endpackage

// File: rtl/cxchg_sub.sv
module cxchg_sub
   import cxchg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   input  width_e            wsel,
   output logic [DATA_W-1:0] diff,
   output flags_t            flg,
   output logic              is_equal
);

   initial begin
      if (DATA_W < MAX_OP_W)
         $error("cxchg_sub: DATA_W must be at least %0d", MAX_OP_W);
   end

   logic [NUM_LANES-1:0][DATA_W-1:0] lane_diff;
   logic [NUM_LANES-1:0]             lane_cry;
   logic [NUM_LANES-1:0]             lane_sgn;
   logic [NUM_LANES-1:0]             lane_ovf;

   // One subtractor per supported width; the selector picks one lane.
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam int LW = 8 << g;
      logic [LW:0] ext;
      logic        top_a;
      logic        top_b;
      assign ext          = {1'b0, minuend[LW-1:0]} - {1'b0, subtrahend[LW-1:0]};
      assign top_a        = minuend[LW-1];
      assign top_b        = subtrahend[LW-1];
      assign lane_diff[g] = DATA_W'(ext[LW-1:0]);
      assign lane_cry[g]  = ext[LW];
      assign lane_sgn[g]  = ext[LW-1];
      assign lane_ovf[g]  = (top_a ^ top_b) & (top_a ^ ext[LW-1]);
   end

   logic [4:0]  nib_ext;
   int unsigned sel;

   assign nib_ext = {1'b0, minuend[3:0]} - {1'b0, subtrahend[3:0]};

   always_comb begin
      sel       = lane_of(wsel);
      diff      = lane_diff[sel];
      flg.cry   = lane_cry[sel];
      flg.sgn   = lane_sgn[sel];
      flg.ovf   = lane_ovf[sel];
      flg.aux   = nib_ext[4];
      flg.par   = ~^diff[7:0];
      flg.zro   = (diff == '0);
      is_equal  = flg.zro;
   end

endmodule

// File: rtl/cxchg_merge.sv
module cxchg_merge
   import cxchg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  width_e            wsel,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] new_val,
   output logic [DATA_W-1:0] merged
);

   localparam int NBYTES = DATA_W / 8;

   initial begin
      if (DATA_W % 8 != 0)
         $error("cxchg_merge: DATA_W must be a whole number of bytes");
   end

   logic [NBYTES-1:0] byte_en;

   // A byte is replaced when it lies inside the selected width.
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign byte_en[b] = (b * 8) < int'(lane_bits(lane_of(wsel)));
      assign merged[b*8 +: 8] = byte_en[b] ? new_val[b*8 +: 8] : old_val[b*8 +: 8];
   end

endmodule

// File: rtl/cxchg_unit.sv
module cxchg_unit
   import cxchg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_width,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] dst_in,
   input  logic [DATA_W-1:0] src_in,
   output logic              res_valid,
   output logic              acc_we,
   output logic [DATA_W-1:0] acc_out,
   output logic              dst_we,
   output logic [DATA_W-1:0] dst_out,
   output logic [FLAG_W-1:0] flags
);

   initial begin
      if (DATA_W < MAX_OP_W || DATA_W % 8 != 0)
         $error("cxchg_unit: DATA_W must be a byte multiple of at least %0d", MAX_OP_W);
   end

   width_e            wsel;
   logic [DATA_W-1:0] diff;
   flags_t            flg;
   logic              match;
   logic [DATA_W-1:0] acc_merged;
   logic [DATA_W-1:0] dst_merged;

   assign wsel = width_e'(op_width);

   cxchg_sub #(.DATA_W(DATA_W)) u_sub (
      .minuend    (acc_in),
      .subtrahend (dst_in),
      .wsel       (wsel),
      .diff       (diff),
      .flg        (flg),
      .is_equal   (match)
   );

   // Accumulator receives the destination on a mismatch.
   cxchg_merge #(.DATA_W(DATA_W)) u_acc_merge (
      .wsel    (wsel),
      .old_val (acc_in),
      .new_val (dst_in),
      .merged  (acc_merged)
   );

   // Destination receives the source on a match.
   cxchg_merge #(.DATA_W(DATA_W)) u_dst_merge (
      .wsel    (wsel),
      .old_val (dst_in),
      .new_val (src_in),
      .merged  (dst_merged)
   );

   logic              nx_acc_we;
   logic              nx_dst_we;
   logic [DATA_W-1:0] nx_acc;
   logic [DATA_W-1:0] nx_dst;

   always_comb begin
      nx_acc_we = op_valid & ~match;
      nx_dst_we = op_valid & match;
      nx_acc    = match ? acc_in : acc_merged;
      nx_dst    = match ? dst_merged : dst_in;
   end

   if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] acc_in_q;
      logic [DATA_W-1:0] dst_in_q;
      width_e            wsel_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            acc_we    <= 1'b0;
            dst_we    <= 1'b0;
            acc_out   <= '0;
            dst_out   <= '0;
            flags     <= '0;
            acc_in_q  <= '0;
            dst_in_q  <= '0;
            wsel_q    <= WID_8;
         end else begin
            res_valid <= op_valid;
            acc_we    <= nx_acc_we;
            dst_we    <= nx_dst_we;
            acc_in_q  <= acc_in;
            dst_in_q  <= dst_in;
            wsel_q    <= wsel;
            if (op_valid) begin
               acc_out <= nx_acc;
               dst_out <= nx_dst;
               flags   <= flg;
            end
         end
      end

      AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid |=> res_valid) else $error("latency"); // R10
      AST_DST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && acc_we) |-> (dst_out == dst_in_q)) else $error("dst held"); // R8
      AST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && dst_we) |-> (acc_out == acc_in_q)) else $error("acc held"); // R7
      AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && acc_we && wsel_q == WID_8)
            |-> (acc_out[DATA_W-1:8] == acc_in_q[DATA_W-1:8])) else $error("upper"); // R9
   end else begin : g_comb
      always_comb begin
         res_valid = op_valid;
         acc_we    = nx_acc_we;
         dst_we    = nx_dst_we;
         acc_out   = nx_acc;
         dst_out   = nx_dst;
         flags     = flg;
      end
   end

   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones({acc_we, dst_we}) == 1)) else $error("one write"); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!acc_we && !dst_we)) else $error("idle"); // R10
   AST_ZERO_PICKS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && flags[3]) |-> dst_we) else $error("zero to dst"); // R7
   AST_NONZERO_PICKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !flags[3]) |-> acc_we) else $error("nonzero to acc"); // R8

endmodule

// File: tb/cxchg_unit_tb.sv
`timescale 1ns/1ps
module cxchg_unit_tb;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op_width = 2'd0;
   logic [DW-1:0] acc_in = '0;
   logic [DW-1:0] dst_in = '0;
   logic [DW-1:0] src_in = '0;
   logic          res_valid;
   logic          acc_we;
   logic [DW-1:0] acc_out;
   logic          dst_we;
   logic [DW-1:0] dst_out;
   logic [5:0]    flags;

   always #2 clk = ~clk;

   cxchg_unit #(.DATA_W(DW), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_width(op_width),
      .acc_in(acc_in), .dst_in(dst_in), .src_in(src_in),
      .res_valid(res_valid), .acc_we(acc_we), .acc_out(acc_out),
      .dst_we(dst_we), .dst_out(dst_out), .flags(flags)
   );

   typedef struct {
      logic [DW-1:0] acc;
      logic [DW-1:0] dst;
      logic          awe;
      logic          dwe;
      logic [5:0]    flg;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 0;

   task automatic check(string req, string what, longint act, longint expv);
      n_run++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // Reference model built from the requirement text.
   function automatic exp_t model(int w, logic [DW-1:0] a_in, logic [DW-1:0] d_in,
                                  logic [DW-1:0] s_in, string tag);
      exp_t   e;
      int     bits;
      longint msk, a, b, d, sa, sb, sd, half;
      bits = (w == 0) ? 8 : (w == 1) ? 16 : 32;
      msk  = (64'd1 << bits) - 1;
      half = 64'd1 << (bits - 1);
      a    = longint'(a_in) & msk;
      b    = longint'(d_in) & msk;
      d    = (a - b) & msk;
      sa   = (a >= half) ? a - (64'd1 << bits) : a;
      sb   = (b >= half) ? b - (64'd1 << bits) : b;
      sd   = sa - sb;
      e.flg[0] = (a < b);
      e.flg[1] = ($countones(d & 255) % 2) == 0;
      e.flg[2] = (a & 15) < (b & 15);
      e.flg[3] = (d == 0);
      e.flg[4] = ((d >> (bits - 1)) & 1) == 1;
      e.flg[5] = (sd < -half) || (sd >= half);
      e.awe = (d != 0);
      e.dwe = (d == 0);
      e.acc = a_in;
      e.dst = d_in;
      if (d == 0) e.dst = DW'((longint'(d_in) & ~msk) | (longint'(s_in) & msk));
      else        e.acc = DW'((longint'(a_in) & ~msk) | b);
      e.tag = tag;
      return e;
   endfunction

   task automatic send(int w, logic [DW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] s, string tag);
      @(negedge clk);
      op_valid = 1'b1;
      op_width = 2'(w);
      acc_in   = a;
      dst_in   = d;
      src_in   = s;
      exp_q.push_back(model(w, a, d, s, tag));
   endtask

   task automatic idle();
      @(negedge clk);
      op_valid = 1'b0;
      acc_in   = 32'hDEAD_BEEF;
      dst_in   = 32'h1234_5678;
   endtask

   // Monitor: pops one expected item per valid result.
   always @(negedge clk) begin
      if (rst_n && !done && res_valid) begin
         if (exp_q.size() == 0) begin
            check("R10", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check("R1", "zero flag", longint'(flags[3]), longint'(e.flg[3]));
            check("R2", "carry flag", longint'(flags[0]), longint'(e.flg[0]));
            check("R3", "overflow flag", longint'(flags[5]), longint'(e.flg[5]));
            check("R4", "sign flag", longint'(flags[4]), longint'(e.flg[4]));
            check("R5", "aux flag", longint'(flags[2]), longint'(e.flg[2]));
            check("R6", "parity flag", longint'(flags[1]), longint'(e.flg[1]));
            check(e.dwe ? "R7" : "R8", "acc_we", longint'(acc_we), longint'(e.awe));
            check(e.dwe ? "R7" : "R8", "dst_we", longint'(dst_we), longint'(e.dwe));
            check(e.tag, "acc_out", longint'(acc_out), longint'(e.acc));
            check(e.tag, "dst_out", longint'(dst_out), longint'(e.dst));
         end
      end
   end

   logic [31:0] lfsr = 32'hACE1_2357;
   function automatic logic [31:0] step(logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check("R10", "reset res_valid", longint'(res_valid), 0);
      check("R10", "reset we", longint'({acc_we, dst_we}), 0);
      check("R10", "reset flags", longint'(flags), 0);
      check("R10", "reset acc_out", longint'(acc_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Matches and mismatches at each width.
      send(2, 32'h0000_1234, 32'h0000_1234, 32'hCAFE_F00D, "R7");
      send(2, 32'h0000_1234, 32'h0000_1235, 32'hCAFE_F00D, "R8");
      send(1, 32'hAAAA_00FF, 32'h5555_00FF, 32'h1111_2222, "R9");
      send(0, 32'h1234_5680, 32'h8765_4380, 32'hFFFF_FF77, "R9");
      send(0, 32'hFFFF_FF10, 32'h0000_0020, 32'h0, "R9");
      send(3, 32'h8000_0000, 32'h0000_0001, 32'h0, "R9");
      // Overflow and borrow corners.
      send(0, 32'h80, 32'h01, 32'h0, "R3");
      send(0, 32'h7F, 32'hFF, 32'h0, "R3");
      send(1, 32'h8000, 32'h0001, 32'h0, "R3");
      send(2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R3");
      send(2, 32'h0000_0010, 32'h0000_0001, 32'h0, "R5");
      send(2, 32'h0000_0000, 32'h0000_0001, 32'h0, "R2");
      send(0, 32'h03, 32'h00, 32'h0, "R6");
      send(0, 32'h07, 32'h00, 32'h0, "R6");
      idle();
      @(negedge clk);
      check("R10", "idle res_valid", longint'(res_valid), 0);
      check("R10", "idle we", longint'({acc_we, dst_we}), 0);

      // Pseudo-random stream with forced matches.
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] a, d, s;
         lfsr = step(lfsr); a = lfsr;
         lfsr = step(lfsr); d = lfsr;
         lfsr = step(lfsr); s = lfsr;
         if (lfsr[3:2] == 2'b00) d = {d[31:16], a[15:0]};
         if (lfsr[5:4] == 2'b01) d = a;
         send(int'(lfsr[9:8]), a, d, s, "R1");
      end
      idle();
      repeat (2) @(negedge clk);
      check("R10", "queue drained", longint'(exp_q.size()), 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         n_run++;
         n_fail++;
         $display("FAIL R10 watchdog actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule